// File: doc/BRIEF.md
# Video RAM CPU Read-Conflict Port

This block is the processor-side access port of a two-bank video memory that a pixel-fetch engine also reads. It accepts one read or write request per cycle with an offset into the video window and a bank select. It returns read data one cycle later and keeps a one-byte open-bus latch. The pixel fetcher, the DMA engine and the mode timing all sit outside this block. They report their condition through flags: a fetcher state code, the fetcher's two most recent addresses, read and write block flags, a DMA-read-active flag and a flag saying the DMA destination is video memory.

The main function is the read conflict. While the fetcher sits in its conflict state on a colour device at normal speed, a processor read does not always see its own address. Depending on the device revision and on the top offset bit of the processor and fetcher addresses, the read is steered to one of the fetcher's addresses, returns the open-bus byte, or returns zero. On the newer revision, a read that returns the open-bus byte also refills the latch from the addressed byte.

The array holds two banks of 2^OFFS_W bytes. The default OFFS_W is 11, so the top offset bit, bit 10, plays the role of the tile-data half select. A full-size instance uses OFFS_W = 13, where that bit is bit 12.

Top module: `vram_cpu_port`

## Requirements
- R1: While reset is asserted, and right after it is released, rdValid is 0 and busLatch is 0xFF.
- R2: The array location is {bankSel, offset}. The same offset in bank 0 and bank 1 holds independent bytes.
- R3: A read request (rdReq=1, wrReq=0) raises rdValid for exactly one cycle on the clock edge that accepts it, with rdData valid in that same cycle.
- R4: A normal read returns the byte at its location and loads busLatch with that byte.
- R5: Every write loads busLatch with wrData. When wrBlock=1 the write leaves the array unchanged.
- R6: A read with rdBlock=1 and dmaRdActive=0 returns 0xFF and leaves busLatch unchanged, unless R7 applies. With dmaRdActive=1 the read proceeds.
- R7: When dmaToVram=1, a read goes to its own address regardless of rdBlock and of any conflict, and loads busLatch with the result.
- R8: Conflict handling applies only when fetchState=22, colorMode=1 and dblSpeed=0. Otherwise the read is normal.
- R9: In a conflict with offset top bit set, revSel=0 (older revision) and the top bit of lastDataAddr clear, the read returns 0x00 and busLatch is unchanged.
- R10: In a conflict with offset top bit set, in every case not covered by R9, the read uses lastIdxAddr in place of the processor offset and loads busLatch.
- R11: In a conflict with offset top bit clear, lastDataAddr top bit set and revSel nonzero (newer revision), the read returns the previous busLatch and then loads busLatch with the byte at the processor's own location.
- R12: In the case of R11 with revSel=0, the read returns busLatch and leaves it unchanged.
- R13: In a conflict with both top bits clear, the read uses lastDataAddr in place of the processor offset and loads busLatch.
- R14: When rdReq and wrReq are both 1, the request is handled as a write only, and rdValid stays 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | input | 1 | Read request strobe |
| wrReq | input | 1 | Write request strobe |
| cpuAddr | input | OFFS_W | Processor offset into the video window |
| wrData | input | DATA_W | Write data |
| bankSel | input | 1 | Bank select, 1 = upper bank |
| dblSpeed | input | 1 | Double-speed operation |
| colorMode | input | 1 | Colour device mode |
| revSel | input | 2 | Revision: 0 older, nonzero newer |
| rdBlock | input | 1 | Reads blocked by display mode |
| wrBlock | input | 1 | Writes blocked by display mode |
| dmaRdActive | input | 1 | A DMA read is in progress |
| dmaToVram | input | 1 | DMA destination lies in video memory |
| fetchState | input | STATE_W | Pixel fetcher state code |
| lastIdxAddr | input | OFFS_W | Fetcher's last tile-index offset |
| lastDataAddr | input | OFFS_W | Fetcher's last tile-data offset |
| rdData | output | DATA_W | Registered read data |
| rdValid | output | 1 | One-cycle read-data valid pulse |
| busLatch | output | DATA_W | Open-bus latch |

## Verification
The assertions assume that every sideband flag, every fetcher address and the revision select are stable during the clock edge that accepts a request. The bench therefore changes them only at falling edges, before it raises a strobe. The checks on open-bus values also assume that nothing but a request moves the latch. The bench keeps both strobes low between requests, and it preloads the array only through the write port, so every expected byte follows from the bench's own request history.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  // Source of the byte returned by a read
  typedef enum logic [1:0] {
    SRC_MEM   = 2'd0,
    SRC_ONES  = 2'd1,
    SRC_ZERO  = 2'd2,
    SRC_LATCH = 2'd3
  } rdSrc_e;

  // Which offset drives the array read port
  typedef enum logic [1:0] {
    ADR_CPU  = 2'd0,
    ADR_IDX  = 2'd1,
    ADR_DATA = 2'd2
  } adrSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    memWe;
    logic    rdFire;
    rdSrc_e  rdSrc;
    adrSel_e adrSel;
    logic    latchFromMem;
    logic    latchFromWr;
  } portCmd_t;

endpackage

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
  import vram_port_pkg::*;
#(
  parameter int OFFS_W         = 11,
  parameter int STATE_W        = 5,
  parameter int CONFLICT_STATE = 22
) (
  input  logic               rdReq,
  input  logic               wrReq,
  input  logic [OFFS_W-1:0]  cpuAddr,
  input  logic               dblSpeed,
  input  logic               colorMode,
  input  logic [1:0]         revSel,
  input  logic               rdBlock,
  input  logic               wrBlock,
  input  logic               dmaRdActive,
  input  logic               dmaToVram,
  input  logic [STATE_W-1:0] fetchState,
  input  logic [OFFS_W-1:0]  lastDataAddr,
  output portCmd_t           cmd
);

  localparam int SPLIT = OFFS_W - 1;
  localparam logic [STATE_W-1:0] HOT_STATE = STATE_W'(CONFLICT_STATE);

  logic inConflict;
  logic newRev;
  logic readGated;
  logic cpuHigh;
  logic dataHigh;

  assign inConflict = (fetchState == HOT_STATE) && colorMode && !dblSpeed;
  assign newRev     = (revSel != 2'd0);
  assign readGated  = rdBlock && !dmaRdActive;
  assign cpuHigh    = cpuAddr[SPLIT];
  assign dataHigh   = lastDataAddr[SPLIT];

  always_comb begin
    cmd.memWe        = 1'b0;
    cmd.rdFire       = 1'b0;
    cmd.rdSrc        = SRC_MEM;
    cmd.adrSel       = ADR_CPU;
    cmd.latchFromMem = 1'b0;
    cmd.latchFromWr  = 1'b0;

    if (wrReq) begin
      // latch follows write data even when the array write is suppressed
      cmd.latchFromWr = 1'b1;
      cmd.memWe       = !wrBlock;
    end else if (rdReq) begin
      cmd.rdFire       = 1'b1;
      cmd.latchFromMem = 1'b1;
      if (dmaToVram) begin
        // plain read at own offset
        cmd.rdSrc = SRC_MEM;
      end else if (readGated) begin
        cmd.rdSrc        = SRC_ONES;
        cmd.latchFromMem = 1'b0;
      end else if (inConflict) begin
        if (cpuHigh) begin
          if (!newRev && !dataHigh) begin
            cmd.rdSrc        = SRC_ZERO;
            cmd.latchFromMem = 1'b0;
          end else begin
            cmd.adrSel = ADR_IDX;
          end
        end else if (dataHigh) begin
          cmd.rdSrc        = SRC_LATCH;
          cmd.latchFromMem = newRev;
        end else begin
          cmd.adrSel = ADR_DATA;
        end
      end
    end
  end

endmodule

// File: rtl/vram_port_dpath.sv
module vram_port_dpath
  import vram_port_pkg::*;
#(
  parameter int OFFS_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portCmd_t          cmd,
  input  logic [OFFS_W-1:0] cpuAddr,
  input  logic [OFFS_W-1:0] lastIdxAddr,
  input  logic [OFFS_W-1:0] lastDataAddr,
  input  logic              bankSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] busLatch
);

  localparam int IDX_W = OFFS_W + 1;
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [OFFS_W-1:0] rdOffs;
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  wrIdx;
  logic [DATA_W-1:0] memByte;
  logic [DATA_W-1:0] retByte;

  always_comb begin
    unique case (cmd.adrSel)
      ADR_IDX:  rdOffs = lastIdxAddr;
      ADR_DATA: rdOffs = lastDataAddr;
      default:  rdOffs = cpuAddr;
    endcase
  end

  assign rdIdx   = {bankSel, rdOffs};
  assign wrIdx   = {bankSel, cpuAddr};
  assign memByte = memArr[rdIdx];

  always_comb begin
    unique case (cmd.rdSrc)
      SRC_ONES:  retByte = '1;
      SRC_ZERO:  retByte = '0;
      SRC_LATCH: retByte = busLatch;
      default:   retByte = memByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (cmd.memWe) memArr[wrIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      busLatch <= '1;
    end else begin
      rdValid <= cmd.rdFire;
      if (cmd.rdFire) rdData <= retByte;
      if (cmd.latchFromWr)       busLatch <= wrData;
      else if (cmd.latchFromMem) busLatch <= memByte;
    end
  end

endmodule

// File: rtl/vram_cpu_port.sv
module vram_cpu_port
  import vram_port_pkg::*;
#(
  parameter int OFFS_W         = 11,
  parameter int DATA_W         = 8,
  parameter int STATE_W        = 5,
  parameter int CONFLICT_STATE = 22
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdReq,
  input  logic               wrReq,
  input  logic [OFFS_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               bankSel,
  input  logic               dblSpeed,
  input  logic               colorMode,
  input  logic [1:0]         revSel,
  input  logic               rdBlock,
  input  logic               wrBlock,
  input  logic               dmaRdActive,
  input  logic               dmaToVram,
  input  logic [STATE_W-1:0] fetchState,
  input  logic [OFFS_W-1:0]  lastIdxAddr,
  input  logic [OFFS_W-1:0]  lastDataAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  output logic [DATA_W-1:0]  busLatch
);

  portCmd_t cmd;

  vram_port_ctrl #(
    .OFFS_W(OFFS_W), .STATE_W(STATE_W), .CONFLICT_STATE(CONFLICT_STATE)
  ) u_ctrl (
    .rdReq(rdReq), .wrReq(wrReq), .cpuAddr(cpuAddr),
    .dblSpeed(dblSpeed), .colorMode(colorMode), .revSel(revSel),
    .rdBlock(rdBlock), .wrBlock(wrBlock), .dmaRdActive(dmaRdActive),
    .dmaToVram(dmaToVram), .fetchState(fetchState),
    .lastDataAddr(lastDataAddr), .cmd(cmd)
  );

  vram_port_dpath #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cpuAddr(cpuAddr),
    .lastIdxAddr(lastIdxAddr), .lastDataAddr(lastDataAddr),
    .bankSel(bankSel), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .busLatch(busLatch)
  );

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk #(
  parameter int OFFS_W         = 11,
  parameter int DATA_W         = 8,
  parameter int STATE_W        = 5,
  parameter int CONFLICT_STATE = 22
) (
  input logic               clk,
  input logic               rstN,
  input logic               rdReq,
  input logic               wrReq,
  input logic [OFFS_W-1:0]  cpuAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic               dblSpeed,
  input logic               colorMode,
  input logic [1:0]         revSel,
  input logic               rdBlock,
  input logic               dmaRdActive,
  input logic               dmaToVram,
  input logic [STATE_W-1:0] fetchState,
  input logic [OFFS_W-1:0]  lastDataAddr,
  input logic [DATA_W-1:0]  rdData,
  input logic               rdValid,
  input logic [DATA_W-1:0]  busLatch
);

  localparam int SPLIT = OFFS_W - 1;

  logic isRd, gated, hot, openRd;
  assign isRd   = rdReq && !wrReq;
  assign gated  = !dmaToVram && rdBlock && !dmaRdActive;
  assign hot    = (fetchState == STATE_W'(CONFLICT_STATE)) && colorMode && !dblSpeed;
  assign openRd = isRd && !dmaToVram && !(rdBlock && !dmaRdActive) && hot;

  // R3
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRd |=> rdValid);

  // R14
  no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isRd |=> !rdValid);

  // R5
  wr_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> busLatch == $past(wrData));

  // R6
  blocked_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && gated) |=> (rdData == '1 && $stable(busLatch)));

  // R9
  zero_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (openRd && cpuAddr[SPLIT] && revSel == 2'd0 && !lastDataAddr[SPLIT])
      |=> (rdData == '0 && $stable(busLatch)));

  // R12
  old_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (openRd && !cpuAddr[SPLIT] && lastDataAddr[SPLIT] && revSel == 2'd0)
      |=> (rdData == $past(busLatch) && $stable(busLatch)));

  // R11
  new_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (openRd && !cpuAddr[SPLIT] && lastDataAddr[SPLIT] && revSel != 2'd0)
      |=> rdData == $past(busLatch));

endmodule

bind vram_cpu_port vram_port_chk #(
  .OFFS_W(OFFS_W), .DATA_W(DATA_W), .STATE_W(STATE_W), .CONFLICT_STATE(CONFLICT_STATE)
) u_chk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .cpuAddr(cpuAddr),
  .wrData(wrData), .dblSpeed(dblSpeed), .colorMode(colorMode), .revSel(revSel),
  .rdBlock(rdBlock), .dmaRdActive(dmaRdActive), .dmaToVram(dmaToVram),
  .fetchState(fetchState), .lastDataAddr(lastDataAddr),
  .rdData(rdData), .rdValid(rdValid), .busLatch(busLatch)
);

// File: tb/vram_cpu_port_bench.sv
module vram_cpu_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OW = 11;

  logic clk = 1'b0;
  logic rstN, rdReq, wrReq, bankSel, dblSpeed, colorMode;
  logic rdBlock, wrBlock, dmaRdActive, dmaToVram;
  logic [OW-1:0] cpuAddr, lastIdxAddr, lastDataAddr;
  logic [7:0] wrData, rdData, busLatch;
  logic [1:0] revSel;
  logic [4:0] fetchState;
  logic rdValid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_cpu_port u_vram_cpu_port (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .cpuAddr(cpuAddr),
    .wrData(wrData), .bankSel(bankSel), .dblSpeed(dblSpeed), .colorMode(colorMode),
    .revSel(revSel), .rdBlock(rdBlock), .wrBlock(wrBlock), .dmaRdActive(dmaRdActive),
    .dmaToVram(dmaToVram), .fetchState(fetchState), .lastIdxAddr(lastIdxAddr),
    .lastDataAddr(lastDataAddr), .rdData(rdData), .rdValid(rdValid), .busLatch(busLatch)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic doWrite(input logic [OW-1:0] a, input logic b, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; bankSel = b; wrData = d; wrReq = 1'b1;
    @(negedge clk);
    wrReq = 1'b0;
  endtask

  task automatic doRead(input logic [OW-1:0] a, input logic b,
                        output logic [7:0] d, output logic v);
    @(negedge clk);
    cpuAddr = a; bankSel = b; rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
    d = rdData; v = rdValid;
  endtask

  task automatic setConflict(input logic on);
    fetchState = on ? 5'd22 : 5'd0;
    colorMode = 1'b1; dblSpeed = 1'b0;
  endtask

  task automatic testReset();
    check("R1 rdValid", int'(rdValid), 0);
    check("R1 busLatch", int'(busLatch), 8'hFF);
  endtask

  task automatic testBasic();
    logic [7:0] d; logic v;
    doWrite(11'h010, 1'b0, 8'h11);
    doWrite(11'h420, 1'b0, 8'h22);
    doWrite(11'h030, 1'b0, 8'h33);
    doWrite(11'h040, 1'b0, 8'h44);
    doWrite(11'h010, 1'b1, 8'h55);
    check("R5 latch after write", int'(busLatch), 8'h55);
    doRead(11'h010, 1'b0, d, v);
    check("R3 valid", int'(v), 1);
    check("R2 bank0 byte", int'(d), 8'h11);
    check("R4 latch loaded", int'(busLatch), 8'h11);
    @(negedge clk);
    check("R3 single pulse", int'(rdValid), 0);
    doRead(11'h010, 1'b1, d, v);
    check("R2 bank1 byte", int'(d), 8'h55);
  endtask

  task automatic testBlockedWrite();
    logic [7:0] d; logic v;
    wrBlock = 1'b1;
    doWrite(11'h010, 1'b0, 8'h99);
    wrBlock = 1'b0;
    check("R5 blocked write latch", int'(busLatch), 8'h99);
    doRead(11'h010, 1'b0, d, v);
    check("R5 blocked write array", int'(d), 8'h11);
  endtask

  task automatic testReadBlock();
    logic [7:0] d; logic v;
    rdBlock = 1'b1;
    doRead(11'h030, 1'b0, d, v);
    check("R6 blocked data", int'(d), 8'hFF);
    check("R6 latch kept", int'(busLatch), 8'h11);
    dmaRdActive = 1'b1;
    doRead(11'h030, 1'b0, d, v);
    dmaRdActive = 1'b0;
    check("R6 dma read proceeds", int'(d), 8'h33);
    rdBlock = 1'b0;
  endtask

  task automatic testDmaWindow();
    logic [7:0] d; logic v;
    doWrite(11'h040, 1'b0, 8'h44);
    rdBlock = 1'b1; dmaToVram = 1'b1; setConflict(1'b1);
    lastDataAddr = 11'h030; lastIdxAddr = 11'h040;
    doRead(11'h010, 1'b0, d, v);
    check("R7 own address", int'(d), 8'h11);
    check("R7 latch loaded", int'(busLatch), 8'h11);
    rdBlock = 1'b0; dmaToVram = 1'b0;
  endtask

  task automatic testBothClear();
    logic [7:0] d; logic v;
    setConflict(1'b1); lastDataAddr = 11'h030;
    doRead(11'h010, 1'b0, d, v);
    check("R13 redirect to data addr", int'(d), 8'h33);
    check("R13 latch", int'(busLatch), 8'h33);
  endtask

  task automatic testGating();
    logic [7:0] d; logic v;
    setConflict(1'b1); lastDataAddr = 11'h030;
    dblSpeed = 1'b1;
    doRead(11'h010, 1'b0, d, v);
    check("R8 double speed normal", int'(d), 8'h11);
    dblSpeed = 1'b0; colorMode = 1'b0;
    doRead(11'h010, 1'b0, d, v);
    check("R8 mono normal", int'(d), 8'h11);
    colorMode = 1'b1; fetchState = 5'd21;
    doRead(11'h010, 1'b0, d, v);
    check("R8 other state normal", int'(d), 8'h11);
  endtask

  task automatic testHighHalf();
    logic [7:0] d; logic v;
    setConflict(1'b1); lastIdxAddr = 11'h040;
    revSel = 2'd1; lastDataAddr = 11'h030;
    doRead(11'h420, 1'b0, d, v);
    check("R10 newer uses idx addr", int'(d), 8'h44);
    check("R10 latch", int'(busLatch), 8'h44);
    revSel = 2'd0; lastDataAddr = 11'h400;
    doRead(11'h420, 1'b0, d, v);
    check("R10 older data high uses idx", int'(d), 8'h44);
    doWrite(11'h7FF, 1'b1, 8'hA5);
    lastDataAddr = 11'h030;
    doRead(11'h420, 1'b0, d, v);
    check("R9 zero", int'(d), 0);
    check("R9 latch kept", int'(busLatch), 8'hA5);
  endtask

  task automatic testOpenBus();
    logic [7:0] d; logic v;
    setConflict(1'b1); lastDataAddr = 11'h400;
    wrBlock = 1'b1;
    doWrite(11'h000, 1'b0, 8'h77);
    wrBlock = 1'b0;
    revSel = 2'd0;
    doRead(11'h010, 1'b0, d, v);
    check("R12 older returns latch", int'(d), 8'h77);
    check("R12 latch kept", int'(busLatch), 8'h77);
    revSel = 2'd1;
    doRead(11'h010, 1'b0, d, v);
    check("R11 newer returns old latch", int'(d), 8'h77);
    check("R11 latch refilled", int'(busLatch), 8'h11);
    doRead(11'h010, 1'b0, d, v);
    check("R11 second read", int'(d), 8'h11);
    setConflict(1'b0);
  endtask

  task automatic testBothStrobes();
    logic [7:0] d; logic v;
    @(negedge clk);
    cpuAddr = 11'h050; bankSel = 1'b0; wrData = 8'h66; wrReq = 1'b1; rdReq = 1'b1;
    @(negedge clk);
    wrReq = 1'b0; rdReq = 1'b0;
    check("R14 no valid", int'(rdValid), 0);
    check("R14 latch from write", int'(busLatch), 8'h66);
    doRead(11'h050, 1'b0, d, v);
    check("R14 written", int'(d), 8'h66);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rdReq = 1'b0; wrReq = 1'b0; bankSel = 1'b0;
    dblSpeed = 1'b0; colorMode = 1'b1; revSel = 2'd0;
    rdBlock = 1'b0; wrBlock = 1'b0; dmaRdActive = 1'b0; dmaToVram = 1'b0;
    cpuAddr = '0; lastIdxAddr = '0; lastDataAddr = '0; wrData = '0;
    fetchState = 5'd0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testBlockedWrite();
    testReadBlock();
    testDmaWindow();
    testBothClear();
    testGating();
    testHighHalf();
    testOpenBus();
    testBothStrobes();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule